// File: doc/BRIEF.md
# Built-in logic block observer register

This block is a W-bit register meant to stand in place of an ordinary system register so that the logic around it can be tested on chip. Two mode inputs select its behaviour. It can act as a plain parallel-load register, clear itself, or work as a scan shift path for loading seeds and unloading results. In its fourth mode it is a multiple-input signature register that folds the parallel inputs into an LFSR state. If those inputs are held at zero, the same mode becomes a free-running pseudo-random pattern source.

A build-time option gives a concurrent variant for registers that both feed and observe the same logic. In this variant the parallel outputs carry a pattern-generator state, and the responses on the parallel inputs are compacted into a second, separate signature state. That state is visible on its own output. A wider register lowers the chance that a faulty response stream leaves the same signature as a good one, so the width and the feedback taps are parameters.

Top module: `bilbo_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, `par_out`, `sig_out` and `ser_out` become 0 at that edge.
- R2: With `{mode_b1,mode_b2}` = 2'b11 (system load), `par_out` takes the value of `par_in` at the next edge.
- R3: With `{mode_b1,mode_b2}` = 2'b01 (clear), every bit of `par_out` and `sig_out` becomes 0 at the next edge.
- R4: With `{mode_b1,mode_b2}` = 2'b00 (scan shift), `ser_in` enters bit 0, each bit i takes the old bit i-1, and `ser_out` shows the top bit of the last stage. In the concurrent variant, the chain runs from `ser_in` through the pattern state (bit W-1 of the pattern state feeds bit 0 of the signature state) to `ser_out` = `sig_out[W-1]`.
- R5: With `{mode_b1,mode_b2}` = 2'b10 (signature), the state becomes `{s[W-2:0], fb} ^ par_in`, where `fb` is the XOR of the bits of s selected by the `TAPS` mask. The default for W=8 is taps at bits 7,3,2,1 (polynomial 1+x^2+x^3+x^4+x^8).
- R6: In signature mode with `par_in` = 0 and the default parameters, a nonzero seed returns to itself after exactly 255 clocks and not earlier.
- R7: In signature mode with `par_in` = 0, an all-zero state stays all-zero, so a seed must be loaded first.
- R8: Concurrent variant, signature mode: `par_out` steps as an LFSR with zero injection whatever `par_in` is, while `sig_out` compacts `par_in` by the rule of R5.
- R9: In the concurrent variant, system load changes `par_out` only and `sig_out` holds. In the default variant, `sig_out` always equals `par_out`.
- R10: Two response streams that differ in a single bit give different signatures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_b1 | input | 1 | Mode control, upper bit |
| mode_b2 | input | 1 | Mode control, lower bit |
| par_in | input | W | Parallel data / response inputs |
| ser_in | input | 1 | Scan serial input |
| par_out | output | W | Register outputs (pattern state in the concurrent variant) |
| sig_out | output | W | Signature state (same as par_out in the default variant) |
| ser_out | output | 1 | Scan serial output |

## Verification
On every cycle, the assertions check the next-state rule of reset, load, clear and shift against the previous cycle's ports. They also check that a zero state with zero injection stays at zero, and that a load leaves the concurrent signature untouched. Some behaviours only the bench scenarios can show: the full signature arithmetic over long input streams, the 255-cycle period of the generator, the scan chain threading through both states, and that a single flipped response bit yields a different final signature.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;
  typedef enum logic [1:0] {
    BM_SHIFT = 2'b00,
    BM_CLEAR = 2'b01,
    BM_SIG   = 2'b10,
    BM_LOAD  = 2'b11
  } bilbo_mode_e;
endpackage

// File: rtl/bilbo_mode_dec.sv
module bilbo_mode_dec
  import bilbo_pkg::*;
(
  input  logic        b1,
  input  logic        b2,
  output bilbo_mode_e mode
);
  assign mode = bilbo_mode_e'({b1, b2});
endmodule

// File: rtl/bilbo_lfsr_next.sv
module bilbo_lfsr_next #(
  parameter int         W    = 8,
  parameter logic [W-1:0] TAPS = 8'h8E
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] inject,
  output logic [W-1:0] nxt
);
  logic fb;
  assign fb  = ^(cur & TAPS);
  assign nxt = {cur[W-2:0], fb} ^ inject;
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
  import bilbo_pkg::*;
#(
  parameter int           W          = 8,
  parameter logic [W-1:0] TAPS       = 8'h8E,
  parameter bit           CONCURRENT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_b1,
  input  logic         mode_b2,
  input  logic [W-1:0] par_in,
  input  logic         ser_in,
  output logic [W-1:0] par_out,
  output logic [W-1:0] sig_out,
  output logic         ser_out
);
  localparam logic [W-1:0] ZERO = '0;

  bilbo_mode_e mode;

  bilbo_mode_dec i_dec (
    .b1   (mode_b1),
    .b2   (mode_b2),
    .mode (mode)
  );

  generate
    if (!CONCURRENT) begin : g_single
      logic [W-1:0] st_q;
      logic [W-1:0] st_step;

      bilbo_lfsr_next #(.W(W), .TAPS(TAPS)) i_step (
        .cur    (st_q),
        .inject (par_in),
        .nxt    (st_step)
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          st_q <= ZERO;
        end else begin
          case (mode)
            BM_LOAD:  st_q <= par_in;
            BM_CLEAR: st_q <= ZERO;
            BM_SHIFT: st_q <= {st_q[W-2:0], ser_in};
            default:  st_q <= st_step;
          endcase
        end
      end

      assign par_out = st_q;
      assign sig_out = st_q;
      assign ser_out = st_q[W-1];

      // R7: a zero state with zero injection never leaves zero
      a_r7_zero_lock: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == BM_SIG && $past(par_in) == ZERO &&
         $past(par_out) == ZERO && !$past(rst)) |-> par_out == ZERO);

    end else begin : g_concurrent
      logic [W-1:0] gen_q;
      logic [W-1:0] sig_q;
      logic [W-1:0] gen_step;
      logic [W-1:0] sig_step;

      bilbo_lfsr_next #(.W(W), .TAPS(TAPS)) i_gen_step (
        .cur    (gen_q),
        .inject (ZERO),
        .nxt    (gen_step)
      );

      bilbo_lfsr_next #(.W(W), .TAPS(TAPS)) i_sig_step (
        .cur    (sig_q),
        .inject (par_in),
        .nxt    (sig_step)
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          gen_q <= ZERO;
          sig_q <= ZERO;
        end else begin
          case (mode)
            BM_LOAD: begin
              gen_q <= par_in;
            end
            BM_CLEAR: begin
              gen_q <= ZERO;
              sig_q <= ZERO;
            end
            BM_SHIFT: begin
              gen_q <= {gen_q[W-2:0], ser_in};
              sig_q <= {sig_q[W-2:0], gen_q[W-1]};
            end
            default: begin
              gen_q <= gen_step;
              sig_q <= sig_step;
            end
          endcase
        end
      end

      assign par_out = gen_q;
      assign sig_out = sig_q;
      assign ser_out = sig_q[W-1];

      // R9: load leaves the signature state alone
      a_r9_load_keeps_sig: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == BM_LOAD && !$past(rst)) |-> sig_out == $past(sig_out));

      // R4: scan chain crosses from pattern state into signature state
      a_r4_chain_link: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == BM_SHIFT && !$past(rst)) |-> sig_out[0] == $past(par_out[W-1]));
    end
  endgenerate

  // R1: reset empties the register
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (par_out == ZERO && sig_out == ZERO && !ser_out));

  // R2: load captures the parallel inputs
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == BM_LOAD && !$past(rst)) |-> par_out == $past(par_in));

  // R3: clear mode zeroes everything
  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == BM_CLEAR && !$past(rst)) |-> (par_out == ZERO && sig_out == ZERO));

  // R4: shift moves one place toward the top
  a_r4_shift: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == BM_SHIFT && !$past(rst)) |->
      (par_out[0] == $past(ser_in) && par_out[W-1:1] == $past(par_out[W-2:0])));
endmodule

// File: tb/test_bilbo_reg.sv
module test_bilbo_reg;
  logic       clk = 1'b0;
  logic       rst;
  logic       b1, b2;
  logic [7:0] zin;
  logic       sin;
  logic [7:0] q, sg, cq, csg;
  logic       so, cso;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  bilbo_reg #(.W(8), .TAPS(8'h8E), .CONCURRENT(1'b0)) i_bilbo_reg (
    .clk(clk), .rst(rst), .mode_b1(b1), .mode_b2(b2), .par_in(zin),
    .ser_in(sin), .par_out(q), .sig_out(sg), .ser_out(so));

  bilbo_reg #(.W(8), .TAPS(8'h8E), .CONCURRENT(1'b1)) i_bilbo_reg_cc (
    .clk(clk), .rst(rst), .mode_b1(b1), .mode_b2(b2), .par_in(zin),
    .ser_in(sin), .par_out(cq), .sig_out(csg), .ser_out(cso));

  typedef struct {
    string      tag;
    logic [7:0] q;
    logic [7:0] cq;
    logic [7:0] csg;
  } exp_t;

  exp_t sbq[$];
  logic [7:0] m_q, m_gen, m_sig;

  function automatic logic [7:0] adv(input logic [7:0] s, input logic [7:0] z);
    logic fb;
    fb = s[7] ^ s[3] ^ s[2] ^ s[1];
    return {s[6:0], fb} ^ z;
  endfunction

  task automatic push(input string tag);
    exp_t e;
    e.tag = tag; e.q = m_q; e.cq = m_gen; e.csg = m_sig;
    sbq.push_back(e);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; b1 = 1'b1; b2 = 1'b1; zin = 8'h00; sin = 1'b0;
    m_q = 8'h00; m_gen = 8'h00; m_sig = 8'h00;
    push(tag);
  endtask

  task automatic step(input logic [1:0] md, input logic [7:0] z, input logic si,
                      input string tag);
    logic [7:0] g0;
    @(negedge clk);
    rst = 1'b0; {b1, b2} = md; zin = z; sin = si;
    g0 = m_gen;
    case (md)
      2'b11: begin m_q = z; m_gen = z; end
      2'b01: begin m_q = 8'h00; m_gen = 8'h00; m_sig = 8'h00; end
      2'b00: begin
        m_q = {m_q[6:0], si}; m_gen = {m_gen[6:0], si}; m_sig = {m_sig[6:0], g0[7]};
      end
      default: begin
        m_q = adv(m_q, z); m_gen = adv(m_gen, 8'h00); m_sig = adv(m_sig, z);
      end
    endcase
    push(tag);
  endtask

  // monitor: pops one expectation per edge, away from the edge
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (sbq.size() > 0) begin
      e = sbq.pop_front();
      checks++;
      if (q !== e.q || sg !== e.q || so !== e.q[7] ||
          cq !== e.cq || csg !== e.csg || cso !== e.csg[7]) begin
        fails++;
        $display("FAIL %s: q=%h sig=%h so=%b cq=%h csig=%h cso=%b expected q=%h sig=%h so=%b cq=%h csig=%h cso=%b",
                 e.tag, q, sg, so, cq, csg, cso, e.q, e.q, e.q[7], e.cq, e.csg, e.csg[7]);
      end
    end
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] sig_a, sig_b;
    bit early;
    rst = 1'b1; b1 = 1'b1; b2 = 1'b1; zin = 8'h00; sin = 1'b0;
    do_reset("R1 reset state");
    do_reset("R1 reset state held");

    // R2 system load, several patterns
    step(2'b11, 8'hA5, 1'b0, "R2 load A5");
    step(2'b11, 8'h3C, 1'b1, "R2 load 3C");
    step(2'b11, 8'hFF, 1'b0, "R2 load FF");
    // R3 clear
    step(2'b01, 8'h77, 1'b1, "R3 clear");
    // R4 shift a walking pattern through both chains
    for (int k = 0; k < 20; k++) step(2'b00, 8'hC3, k[0] ^ k[2], "R4 shift");
    // R1 reset from a loaded state
    step(2'b11, 8'h5A, 1'b0, "R2 load before reset");
    do_reset("R1 reset from loaded");
    // R7 zero lock in signature mode
    for (int k = 0; k < 4; k++) step(2'b10, 8'h00, 1'b0, "R7 zero stays zero");
    // R5 and R8 compaction with varied inputs, seeded generator
    step(2'b11, 8'h81, 1'b0, "R9 load pattern state only");
    for (int k = 0; k < 12; k++) step(2'b10, 8'(k * 29 + 3), 1'b0, "R5 R8 signature step");
    step(2'b11, 8'h12, 1'b0, "R9 load keeps signature");
    step(2'b10, 8'hF0, 1'b0, "R5 R8 signature after load");

    // R6 maximal period from seed 01
    step(2'b11, 8'h01, 1'b0, "R6 seed");
    @(posedge clk); #3;
    early = 1'b0;
    for (int k = 1; k <= 255; k++) begin
      step(2'b10, 8'h00, 1'b0, "R6 PRPG step");
      @(posedge clk); #3;
      if (k < 255 && q == 8'h01) early = 1'b1;
    end
    checks++;
    if (q !== 8'h01 || early) begin
      fails++;
      $display("FAIL R6 period: q=%h early=%b expected q=01 early=0", q, early);
    end

    // R10 single-bit error changes the signature
    do_reset("R1 reset before stream A");
    for (int k = 0; k < 10; k++) step(2'b10, 8'(k * 37 + 1), 1'b0, "R10 stream A");
    @(posedge clk); #3; sig_a = q;
    do_reset("R1 reset before stream B");
    for (int k = 0; k < 10; k++)
      step(2'b10, 8'(k * 37 + 1) ^ ((k == 4) ? 8'h08 : 8'h00), 1'b0, "R10 stream B");
    @(posedge clk); #3; sig_b = q;
    checks++;
    if (sig_a === sig_b) begin
      fails++;
      $display("FAIL R10 aliasing: sigA=%h sigB=%h expected different", sig_a, sig_b);
    end

    @(negedge clk);
    wait (sbq.size() == 0);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule